// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 31 general-purpose input pins and one dedicated interrupt input and turns their activity into five interrupt request lines. The pins are split into four groups: group 0 is pins 7..0, group 1 is pins 15..8, group 2 is pins 23..16 and group 3 is pins 30..24 (seven pins). Each pin has a mask bit of its own. Each group has an enable bit and a single shared flag. Any rise or fall on an unmasked pin sets its group's flag. A request for a group is raised while that flag, the group enable and the global interrupt enable input are all high. A hardware acknowledge per request line, or a write of one to the flag bit, clears the flag.

The dedicated input has a sense mode held as an enumerated state, and a `unique case` chooses the trigger for each mode. SNS_LOW (code 00) requests while the input is low and latches nothing. SNS_ANY (01) latches the flag on either edge. SNS_FALL (10) latches on a falling edge. SNS_RISE (11) latches on a rising edge. A register write moves the mode from any state to any other; there are no automatic transitions. Before edge or level detection, every input passes through a two-flop synchronizer. The request is driven from the pin's own level, so it does not matter whether the surrounding pad drives the pin as an output.

Software reaches the controller through an 8-bit register port with a combinational read.

Top module: `pin_group_irq`

## Requirements
- R1: The register map is: address 0 enable register, address 1 flag register, address 2 sense register, addresses 4..7 pin masks for groups 0..3. In the enable register, bits 7..4 are the enables for groups 3..0 and bit 0 enables the dedicated input. Bits 3..1 of the enable register, bits 7..2 of the sense register and bit 7 of the group 3 mask read as zero and ignore writes.
- R2: After reset, every register reads zero and all request outputs are low.
- R3: A change on a pin whose mask bit is 0 leaves its group flag unchanged.
- R4: A rise or a fall on an unmasked pin sets its group's flag whether or not the group is enabled. The flag register holds the group 3..0 flags in bits 7..4 and the dedicated-input flag in bit 0.
- R5: The request for group g is high exactly when flag g, group enable g and the global enable are all high.
- R6: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a set event and a clear fall in the same cycle, the flag ends up set.
- R7: A one-cycle pulse on an acknowledge input clears the matching flag.
- R8: The edge modes are: sense 11 latches the dedicated flag on a rise only, 10 on a fall only, and 01 on either edge.
- R9: In sense mode 00 the dedicated request follows the input being low, and the dedicated flag is not set.
- R10: A pin change driven before clock edge 1 shows in the flag on edge 3 and not before.
- R11: The dedicated request is high only while its enable and the global enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 31 | General-purpose pin levels |
| ext_i | input | 1 | Dedicated interrupt input |
| gie_i | input | 1 | Global interrupt enable |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| ack_grp_i | input | 4 | Per-group acknowledge, clears the group flag |
| ack_ext_i | input | 1 | Dedicated-input acknowledge |
| irq_grp_o | output | 4 | Group interrupt requests |
| irq_ext_o | output | 1 | Dedicated interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same clock edge as a new set event. The synchronizer delays every pin event by a fixed number of edges, so that edge is hard to hit. The stimulus toggles an unmasked pin just after a falling clock edge and holds the clear write strobe across exactly the third rising edge that follows, which is the edge on which the set event arrives. The same edge count is checked directly: the flag must still be clear after two edges and set after the third.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    localparam logic [2:0] A_ENA = 3'd0;
    localparam logic [2:0] A_FLG = 3'd1;
    localparam logic [2:0] A_SNS = 3'd2;
    localparam logic [2:0] A_MSK = 3'd4;
endpackage

// File: rtl/gpi_sync.sv
// Two-flop synchronizer plus one history stage per bit.
module gpi_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_o  <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= d_i;
            lvl_o  <= meta_q;
            prev_o <= lvl_o;
        end
    end
endmodule

// File: rtl/gpi_grp_flag.sv
// Shared change flag for one pin group.
module gpi_grp_flag #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] lvl_i,
    input  logic [GW-1:0] prev_i,
    input  logic [GW-1:0] mask_i,
    input  logic          clr_i,
    output logic          flag_o
);
    logic hit;

    always_comb hit = |((lvl_i ^ prev_i) & mask_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (hit)    flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    AST_GRP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o); // R4
    AST_GRP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_o); // R6
    AST_GRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !clr_i) |=> $stable(flag_o)); // R3
endmodule

// File: rtl/gpi_ext_sense.sv
// Dedicated input: sense mode chooses edge latch or level request.
module gpi_ext_sense
    import gpi_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode_i,
    input  logic   lvl_i,
    input  logic   prev_i,
    input  logic   clr_i,
    output logic   flag_o,
    output logic   act_o
);
    logic trig;

    always_comb begin
        unique case (mode_i)
            SNS_LOW:  trig = 1'b0;
            SNS_ANY:  trig = lvl_i ^ prev_i;
            SNS_FALL: trig = prev_i & ~lvl_i;
            SNS_RISE: trig = lvl_i & ~prev_i;
            default:  trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (trig)  flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    always_comb act_o = (mode_i == SNS_LOW) ? ~lvl_i : flag_o;

    AST_LVL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SNS_LOW && !flag_o) |=> !flag_o); // R9
    AST_EXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> flag_o); // R8
endmodule

// File: rtl/pin_group_irq.sv
module pin_group_irq
    import gpi_pkg::*;
#(
    parameter int NGRP = 4,
    parameter int GW   = 8,
    parameter int NPIN = 31,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic            ext_i,
    input  logic            gie_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic            bus_we_i,
    input  logic [7:0]      bus_wdata_i,
    output logic [7:0]      bus_rdata_o,
    input  logic [NGRP-1:0] ack_grp_i,
    input  logic            ack_ext_i,
    output logic [NGRP-1:0] irq_grp_o,
    output logic            irq_ext_o
);
    localparam int DW   = 8;
    localparam int PADW = NGRP * GW;

    logic [PADW-1:0]          pin_pad;
    logic [PADW-1:0]          pin_lvl, pin_prev;
    logic                     ext_lvl, ext_prev;
    logic [NGRP-1:0]          grp_en_q;
    logic                     ext_en_q;
    sense_e                   sense_q;
    logic [NGRP-1:0][GW-1:0]  mask_q;
    logic [NGRP-1:0]          grp_flag;
    logic [NGRP-1:0]          grp_clr;
    logic                     ext_flag, ext_act, ext_clr;
    logic                     wr_ena, wr_flg, wr_sns;

    always_comb begin
        pin_pad = '0;
        pin_pad[NPIN-1:0] = pin_i;
    end

    gpi_sync #(.W(PADW)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_pad),
        .lvl_o(pin_lvl), .prev_o(pin_prev)
    );

    gpi_sync #(.W(1)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ext_i),
        .lvl_o(ext_lvl), .prev_o(ext_prev)
    );

    always_comb begin
        wr_ena = bus_we_i && (bus_addr_i == A_ENA);
        wr_flg = bus_we_i && (bus_addr_i == A_FLG);
        wr_sns = bus_we_i && (bus_addr_i == A_SNS);
        grp_clr = ack_grp_i | (wr_flg ? bus_wdata_i[DW-1 -: NGRP] : '0);
        ext_clr = ack_ext_i | (wr_flg & bus_wdata_i[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_en_q <= '0;
            ext_en_q <= 1'b0;
            sense_q  <= SNS_LOW;
        end else begin
            if (wr_ena) begin
                grp_en_q <= bus_wdata_i[DW-1 -: NGRP];
                ext_en_q <= bus_wdata_i[0];
            end
            if (wr_sns) sense_q <= sense_e'(bus_wdata_i[1:0]);
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int REM = NPIN - g * GW;
        localparam int CNT = (REM >= GW) ? GW : ((REM > 0) ? REM : 0);
        localparam logic [GW-1:0] VMASK = GW'((64'd1 << CNT) - 64'd1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[g] <= '0;
            else if (bus_we_i && bus_addr_i == AW'(A_MSK + g))
                mask_q[g] <= bus_wdata_i[GW-1:0] & VMASK;
        end

        gpi_grp_flag #(.GW(GW)) u_flag (
            .clk(clk), .rst_n(rst_n),
            .lvl_i(pin_lvl[g*GW +: GW]), .prev_i(pin_prev[g*GW +: GW]),
            .mask_i(mask_q[g]), .clr_i(grp_clr[g]), .flag_o(grp_flag[g])
        );
    end

    gpi_ext_sense u_ext (
        .clk(clk), .rst_n(rst_n), .mode_i(sense_q),
        .lvl_i(ext_lvl), .prev_i(ext_prev), .clr_i(ext_clr),
        .flag_o(ext_flag), .act_o(ext_act)
    );

    always_comb begin
        irq_grp_o = grp_flag & grp_en_q & {NGRP{gie_i}};
        irq_ext_o = ext_act & ext_en_q & gie_i;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_ENA: begin
                bus_rdata_o[DW-1 -: NGRP] = grp_en_q;
                bus_rdata_o[0]            = ext_en_q;
            end
            A_FLG: begin
                bus_rdata_o[DW-1 -: NGRP] = grp_flag;
                bus_rdata_o[0]            = ext_flag;
            end
            A_SNS:   bus_rdata_o[1:0] = sense_q;
            default: begin
                for (int g = 0; g < NGRP; g++)
                    if (bus_addr_i == AW'(A_MSK + g)) bus_rdata_o = mask_q[g];
            end
        endcase
    end

    AST_GRP_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_grp_o) |-> gie_i); // R5
    AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ext_o |-> (gie_i && ext_en_q)); // R11
endmodule

// File: tb/sim_pin_group_irq.sv
`timescale 1ns/1ps
module sim_pin_group_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] pin = '0;
    logic        ext = 1'b0;
    logic        gie = 1'b0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  ack_grp = '0;
    logic        ack_ext = 1'b0;
    logic [3:0]  irq_grp;
    logic        irq_ext;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pin_group_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .ext_i(ext), .gie_i(gie),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .ack_grp_i(ack_grp), .ack_ext_i(ack_ext),
        .irq_grp_o(irq_grp), .irq_ext_o(irq_ext)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pin_set(input int i, input logic v);
        @(negedge clk); pin[i] = v; settle();
    endtask

    task automatic ext_set(input logic v);
        @(negedge clk); ext = v; settle();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == 8'h00, "R2 register reset", d, 0);
        end
        chk(irq_grp == 4'h0 && irq_ext == 1'b0, "R2 requests low", {irq_grp, irq_ext}, 0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(3'd0, 8'hFF); rd(3'd0, d);
        chk(d == 8'hF1, "R1 enable reserved bits", d, 8'hF1);
        wr(3'd2, 8'hFF); rd(3'd2, d);
        chk(d == 8'h03, "R1 sense reserved bits", d, 8'h03);
        wr(3'd7, 8'hFF); rd(3'd7, d);
        chk(d == 8'h7F, "R1 group 3 mask bit 7", d, 8'h7F);
        wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd7, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] d;
        wr(3'd4, 8'h01);
        pin_set(3, 1'b1); rd(3'd1, d);
        chk(d == 8'h00, "R3 masked pin ignored", d, 0);
        pin_set(0, 1'b1); rd(3'd1, d);
        chk(d == 8'h10, "R4 unmasked pin sets flag", d, 8'h10);
        wr(3'd1, 8'h00); rd(3'd1, d);
        chk(d == 8'h10, "R6 write 0 keeps flag", d, 8'h10);
        wr(3'd1, 8'h10); rd(3'd1, d);
        chk(d == 8'h00, "R6 write 1 clears flag", d, 0);
    endtask

    task automatic t_groups();
        logic [7:0] d;
        for (int g = 0; g < 4; g++) begin
            wr(3'(4 + g), 8'hFF);
            pin_set(g * 8 + 1, 1'b1); rd(3'd1, d);
            chk(d == 8'(1 << (4 + g)), "R4 rise sets group flag", d, 1 << (4 + g));
            wr(3'd1, 8'hF0);
            pin_set(g * 8 + 1, 1'b0); rd(3'd1, d);
            chk(d == 8'(1 << (4 + g)), "R4 fall sets group flag", d, 1 << (4 + g));
            wr(3'd1, 8'hF0);
        end
        pin_set(30, 1'b1); rd(3'd1, d);
        chk(d == 8'h80, "R4 pin 30 in group 3", d, 8'h80);
        wr(3'd1, 8'hF0);
    endtask

    task automatic t_latency();
        @(negedge clk); addr = 3'd1; pin[2] = ~pin[2];
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        chk(rdata[4] == 1'b0, "R10 flag not set after 2 edges", rdata, 0);
        @(posedge clk); @(negedge clk); #1;
        chk(rdata[4] == 1'b1, "R10 flag set on 3rd edge", rdata, 8'h10);
        wr(3'd1, 8'hF0);
    endtask

    task automatic t_request();
        pin_set(9, 1'b1);
        gie = 1'b0; wr(3'd0, 8'h20); #1;
        chk(irq_grp == 4'h0, "R5 no request without global enable", irq_grp, 0);
        gie = 1'b1; wr(3'd0, 8'h00); #1;
        chk(irq_grp == 4'h0, "R5 no request without group enable", irq_grp, 0);
        wr(3'd0, 8'h20); #1;
        chk(irq_grp == 4'h2, "R5 request with all enables", irq_grp, 2);
    endtask

    task automatic t_ack();
        logic [7:0] d;
        @(negedge clk); ack_grp = 4'b0010;
        @(negedge clk); ack_grp = 4'b0000; #1;
        chk(irq_grp == 4'h0, "R7 acknowledge drops request", irq_grp, 0);
        rd(3'd1, d);
        chk(d == 8'h00, "R7 acknowledge clears flag", d, 0);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        @(negedge clk); pin[17] = ~pin[17];
        @(negedge clk);
        @(negedge clk); addr = 3'd1; wdata = 8'h40; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(3'd1, d);
        chk(d == 8'h40, "R6 set wins over same-cycle clear", d, 8'h40);
        wr(3'd1, 8'hF0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_ext_edges();
        logic [7:0] d;
        gie = 1'b1; wr(3'd0, 8'h01); wr(3'd2, 8'h03); wr(3'd1, 8'h01);
        ext_set(1'b1); rd(3'd1, d);
        chk(d == 8'h01, "R8 rise mode latches rise", d, 1);
        chk(irq_ext == 1'b1, "R11 dedicated request raised", irq_ext, 1);
        @(negedge clk); ack_ext = 1'b1; @(negedge clk); ack_ext = 1'b0;
        rd(3'd1, d);
        chk(d == 8'h00, "R7 dedicated acknowledge clears", d, 0);
        ext_set(1'b0); rd(3'd1, d);
        chk(d == 8'h00, "R8 rise mode ignores fall", d, 0);
        wr(3'd2, 8'h02);
        ext_set(1'b1); rd(3'd1, d);
        chk(d == 8'h00, "R8 fall mode ignores rise", d, 0);
        ext_set(1'b0); rd(3'd1, d);
        chk(d == 8'h01, "R8 fall mode latches fall", d, 1);
        wr(3'd1, 8'h01); wr(3'd2, 8'h01);
        ext_set(1'b1); rd(3'd1, d);
        chk(d == 8'h01, "R8 any-edge mode latches rise", d, 1);
        wr(3'd1, 8'h01);
        ext_set(1'b0); rd(3'd1, d);
        chk(d == 8'h01, "R8 any-edge mode latches fall", d, 1);
        wr(3'd1, 8'h01);
    endtask

    task automatic t_level();
        logic [7:0] d;
        wr(3'd2, 8'h00); settle(); #1;
        chk(irq_ext == 1'b1, "R9 low level requests", irq_ext, 1);
        rd(3'd1, d);
        chk(d == 8'h00, "R9 level mode latches no flag", d, 0);
        ext_set(1'b1); #1;
        chk(irq_ext == 1'b0, "R9 high level no request", irq_ext, 0);
        ext_set(1'b0); rd(3'd1, d);
        chk(d == 8'h00 && irq_ext == 1'b1, "R9 request follows level, no flag", {d, irq_ext}, 1);
        wr(3'd0, 8'h00); #1;
        chk(irq_ext == 1'b0, "R11 dedicated enable off", irq_ext, 0);
        wr(3'd0, 8'h01); gie = 1'b0; #1;
        chk(irq_ext == 1'b0, "R11 global enable off", irq_ext, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_masked();
        t_groups();
        t_latency();
        t_request();
        t_ack();
        t_priority();
        t_ext_edges();
        t_level();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule